// File: doc/BRIEF.md
# Indexed Processor Configuration Register File

This block holds a small group of processor configuration control registers that sit behind an index port and a data port. A host first loads an 8-bit index, then reads or writes the register that index selects through the data port. Reads are combinational from the stored index, and writes take effect at the next clock edge. The decoded control bits drive the rest of the core through dedicated output ports.

The block enforces the access rules of the register set. Bits that have no function read back as fixed values: zero, except one test bit that always reads one. A map-enable bit decides whether registers outside the basic window are visible. A lock bit protects the system-management related bits unless the core reports that it is in system-management (SMI) mode. A lock output vetoes changes to the external write-policy (NW) cache-mode bit. Indices that are not implemented, or that are hidden, read as FFh and ignore writes.

Top module: `cfg_regfile`

## Requirements
- R1: After reset the index register holds 00h. Index C1h reads 00h, C2h reads 40h, C3h reads 00h, and E8h reads 85h once it is visible.
- R2: The data port always acts on the most recently written index. A read returns the selected register in the same cycle the index is held. A data write changes the register from the next clock edge.
- R3: Only bits 2:1 of C1h are writable. C2h bits 7, 4, 3 and 2 are writable and bit 6 always reads 1. All C3h bits except bit 2 are writable. Every other bit of these registers reads 0, so writing FFh yields 06h, DCh and FBh.
- R4: Any index other than C1h, C2h, C3h and E8h reads FFh, and writes to it change no register.
- R5: While map-enable (C3h bit 4) is 0, index E8h reads FFh and ignores writes. While it is 1, all 8 bits of E8h are readable and writable.
- R6: While the lock (C3h bit 0) is 1 and smi_mode is 0, writes leave C1h bits 2:1 and C3h bit 1 unchanged. The other writable bits in the same write still update. The lock value held before the write is the one that applies.
- R7: While smi_mode is 1, the protected bits are writable whatever the lock value.
- R8: Any write may set the lock. A write can clear the lock only while smi_mode is 1.
- R9: The output ports mirror the register bits as follows. smm_insn_en is C1h[2] and smi_pin_en is C1h[1]. From C2h: susp_pins_en is [7], wt_region1 is [4], susp_on_halt is [3] and nw_lock is [2]. From C3h: ser_range is [7:5], map_en is [4], susp_in_smm is [3], nmi_in_smm is [1] and smi_lock is [0]. ext_cfg is E8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smi_mode | input | 1 | Core is in system-management mode |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 8 (IDX_W) | Index value |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 8 | Data write value |
| dat_rdata | output | 8 | Selected register value, FFh when absent or hidden |
| smm_insn_en | output | 1 | SMM instruction recognition enable |
| smi_pin_en | output | 1 | SMI input pin enable |
| susp_pins_en | output | 1 | Suspend request and acknowledge enable |
| wt_region1 | output | 1 | Force write-through in the 640 KB to 1 MB region |
| susp_on_halt | output | 1 | Suspend after HALT |
| nw_lock | output | 1 | Veto for changes to the external NW cache-mode bit |
| ser_range | output | 3 | Strong ordering for the three upper 1 GB ranges |
| map_en | output | 1 | Extended register visibility |
| susp_in_smm | output | 1 | Suspend requests honoured in SMM |
| nmi_in_smm | output | 1 | NMI honoured in SMM |
| smi_lock | output | 1 | Lock for the protected bits |
| ext_cfg | output | 8 | Contents of index E8h |

## Verification
After each stimulus step the bench reads back all 256 indices, so a decode alias, a leaked write or a wrong fixed bit shows up at every address and not only at the one just written. The data values 00h, FFh, A5h and 5Ah are written to each register. Together they toggle every bit both ways, which separates writable bits from fixed ones and catches swapped lanes. Each register pattern runs under every combination of lock and smi_mode and with map-enable both off and on. These runs tell dropped protected bits apart from wrongly dropped neighbours, and a sticky lock apart from a clearable one.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int DW = 8;

   localparam logic [7:0] IDX_R1 = 8'hC1;
   localparam logic [7:0] IDX_R2 = 8'hC2;
   localparam logic [7:0] IDX_R3 = 8'hC3;
   localparam logic [7:0] WIN_LO = 8'hC1;
   localparam logic [7:0] WIN_HI = 8'hCF;
   localparam logic [7:0] WIN_T0 = 8'hFE;
   localparam logic [7:0] WIN_T1 = 8'hFF;

   // reset value (also value of fixed bits), writable, protected, set-sticky
   localparam logic [7:0] R1_RST = 8'h00, R1_WM = 8'h06, R1_PM = 8'h06, R1_SM = 8'h00;
   localparam logic [7:0] R2_RST = 8'h40, R2_WM = 8'h9C, R2_PM = 8'h00, R2_SM = 8'h00;
   localparam logic [7:0] R3_RST = 8'h00, R3_WM = 8'hFB, R3_PM = 8'h02, R3_SM = 8'h01;

   typedef struct packed {
      logic r1;
      logic r2;
      logic r3;
      logic ext;
      logic vis;
   } sel_t;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
   import cfg_pkg::*;
#(
   parameter int          IDX_W   = 8,
   parameter logic [7:0]  EXT_IDX = 8'hE8
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             map_en,
   output sel_t             sel
);
   localparam int PAD = IDX_W - 8;

   if (IDX_W < 8) begin : g_bad_w
      $error("cfg_decode: IDX_W must be at least 8");
   end

   logic hi_zero, in_win, ext_hit;
   logic [7:0] lo;

   generate
      if (PAD > 0) begin : g_pad
         assign hi_zero = (idx[IDX_W-1:8] == '0);
      end else begin : g_nopad
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign lo = idx[7:0];
   assign in_win = hi_zero && (((lo >= WIN_LO) && (lo <= WIN_HI)) ||
                               (lo == WIN_T0) || (lo == WIN_T1));
   assign ext_hit = hi_zero && (lo == EXT_IDX);

   always_comb begin
      sel     = '0;
      sel.r1  = hi_zero && (lo == IDX_R1);
      sel.r2  = hi_zero && (lo == IDX_R2);
      sel.r3  = hi_zero && (lo == IDX_R3);
      sel.ext = ext_hit && (map_en || in_win);
      sel.vis = sel.r1 || sel.r2 || sel.r3 || sel.ext;
   end
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0,
   parameter logic [W-1:0] WM  = '1,
   parameter logic [W-1:0] PM  = '0,
   parameter logic [W-1:0] SM  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wd,
   input  logic         prot_ok,
   input  logic         clr_ok,
   output logic [W-1:0] q
);
   if ((PM & ~WM) != '0 || (SM & ~WM) != '0 || (PM & SM) != '0) begin : g_bad_mask
      $error("cfg_reg: inconsistent bit masks");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (!WM[i]) begin : g_fixed
         assign q[i] = RST[i];
      end else if (SM[i]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q[i] <= RST[i];
            else if (we) q[i] <= clr_ok ? wd[i] : (q[i] | wd[i]);
         end
      end else if (PM[i]) begin : g_prot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             q[i] <= RST[i];
            else if (we && prot_ok) q[i] <= wd[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q[i] <= RST[i];
            else if (we) q[i] <= wd[i];
         end
      end
   end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_pkg::*;
#(
   parameter int         IDX_W    = 8,
   parameter logic [7:0] EXT_IDX  = 8'hE8,
   parameter logic [7:0] EXT_RST  = 8'h85,
   parameter logic [7:0] MISS_VAL = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smi_mode,
   input  logic             idx_we,
   input  logic [IDX_W-1:0] idx_wdata,
   input  logic             dat_we,
   input  logic [7:0]       dat_wdata,
   output logic [7:0]       dat_rdata,
   output logic             smm_insn_en,
   output logic             smi_pin_en,
   output logic             susp_pins_en,
   output logic             wt_region1,
   output logic             susp_on_halt,
   output logic             nw_lock,
   output logic [2:0]       ser_range,
   output logic             map_en,
   output logic             susp_in_smm,
   output logic             nmi_in_smm,
   output logic             smi_lock,
   output logic [7:0]       ext_cfg
);
   if (EXT_IDX == IDX_R1 || EXT_IDX == IDX_R2 || EXT_IDX == IDX_R3) begin : g_bad_ext
      $error("cfg_regfile: EXT_IDX collides with a basic register");
   end

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       q1, q2, q3, q8;
   sel_t             sel;
   logic             prot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= idx_wdata;
   end

   cfg_decode #(.IDX_W(IDX_W), .EXT_IDX(EXT_IDX)) u_dec (
      .idx(idx_q), .map_en(q3[4]), .sel(sel)
   );

   assign prot_ok = !q3[0] || smi_mode;

   cfg_reg #(.W(DW), .RST(R1_RST), .WM(R1_WM), .PM(R1_PM), .SM(R1_SM)) u_r1 (
      .clk(clk), .rst_n(rst_n), .we(dat_we && sel.r1), .wd(dat_wdata),
      .prot_ok(prot_ok), .clr_ok(smi_mode), .q(q1)
   );
   cfg_reg #(.W(DW), .RST(R2_RST), .WM(R2_WM), .PM(R2_PM), .SM(R2_SM)) u_r2 (
      .clk(clk), .rst_n(rst_n), .we(dat_we && sel.r2), .wd(dat_wdata),
      .prot_ok(prot_ok), .clr_ok(smi_mode), .q(q2)
   );
   cfg_reg #(.W(DW), .RST(R3_RST), .WM(R3_WM), .PM(R3_PM), .SM(R3_SM)) u_r3 (
      .clk(clk), .rst_n(rst_n), .we(dat_we && sel.r3), .wd(dat_wdata),
      .prot_ok(prot_ok), .clr_ok(smi_mode), .q(q3)
   );
   cfg_reg #(.W(DW), .RST(EXT_RST), .WM(8'hFF), .PM(8'h00), .SM(8'h00)) u_ext (
      .clk(clk), .rst_n(rst_n), .we(dat_we && sel.ext), .wd(dat_wdata),
      .prot_ok(prot_ok), .clr_ok(smi_mode), .q(q8)
   );

   always_comb begin
      dat_rdata = MISS_VAL;
      if (sel.r1)       dat_rdata = q1;
      else if (sel.r2)  dat_rdata = q2;
      else if (sel.r3)  dat_rdata = q3;
      else if (sel.ext) dat_rdata = q8;
   end

   assign smm_insn_en  = q1[2];
   assign smi_pin_en   = q1[1];
   assign susp_pins_en = q2[7];
   assign wt_region1   = q2[4];
   assign susp_on_halt = q2[3];
   assign nw_lock      = q2[2];
   assign ser_range    = q3[7:5];
   assign map_en       = q3[4];
   assign susp_in_smm  = q3[3];
   assign nmi_in_smm   = q3[1];
   assign smi_lock     = q3[0];
   assign ext_cfg      = q8;

   // R6: protected bits hold when locked outside SMI mode
   a_r6_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && sel.r1 && smi_lock && !smi_mode) |=> $stable({smm_insn_en, smi_pin_en}));

   // R7: in SMI mode the NMI bit of the third register follows the data written
   a_r7_smi_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && sel.r3 && smi_mode) |=> (nmi_in_smm == $past(dat_wdata[1])));

   // R8: lock only falls when SMI mode was present
   a_r8_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_lock) |-> $past(smi_mode));

   // R5: hidden extended register ignores writes
   a_r5_ext_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && idx_q == IDX_W'(EXT_IDX) && !map_en) |=> $stable(ext_cfg));

   // R4: absent indices read the miss value
   a_r4_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q[7:0] != IDX_R1 && idx_q[7:0] != IDX_R2 && idx_q[7:0] != IDX_R3 &&
       idx_q[7:0] != EXT_IDX) |-> (dat_rdata == MISS_VAL));
endmodule

// File: tb/tb_cfg_regfile.sv
module tb_cfg_regfile;
   logic clk = 0, rst_n = 0, smi_mode = 0;
   logic idx_we = 0, dat_we = 0;
   logic [7:0] idx_wdata = 0, dat_wdata = 0, dat_rdata, ext_cfg;
   logic smm_insn_en, smi_pin_en, susp_pins_en, wt_region1, susp_on_halt, nw_lock;
   logic [2:0] ser_range;
   logic map_en, susp_in_smm, nmi_in_smm, smi_lock;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] m1, m2, m3, m8;

   always #2 clk = ~clk;

   cfg_regfile dut (
      .clk(clk), .rst_n(rst_n), .smi_mode(smi_mode), .idx_we(idx_we),
      .idx_wdata(idx_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
      .dat_rdata(dat_rdata), .smm_insn_en(smm_insn_en), .smi_pin_en(smi_pin_en),
      .susp_pins_en(susp_pins_en), .wt_region1(wt_region1),
      .susp_on_halt(susp_on_halt), .nw_lock(nw_lock), .ser_range(ser_range),
      .map_en(map_en), .susp_in_smm(susp_in_smm), .nmi_in_smm(nmi_in_smm),
      .smi_lock(smi_lock), .ext_cfg(ext_cfg)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rd(logic [7:0] i);
      if (i == 8'hC1) return m1;
      if (i == 8'hC2) return m2;
      if (i == 8'hC3) return m3;
      if (i == 8'hE8 && m3[4]) return m8;
      return 8'hFF;
   endfunction

   function automatic string tag(logic [7:0] i);
      if (i == 8'hE8) return "R5";
      if (i == 8'hC1 || i == 8'hC2 || i == 8'hC3) return "R3";
      return "R4";
   endfunction

   task automatic set_idx(logic [7:0] i);
      @(negedge clk); idx_we = 1; idx_wdata = i;
      @(negedge clk); idx_we = 0;
   endtask

   task automatic wr(logic [7:0] i, logic [7:0] d);
      logic [7:0] n;
      logic prot;
      set_idx(i);
      dat_we = 1; dat_wdata = d;
      @(negedge clk); dat_we = 0;
      prot = !m3[0] || smi_mode;
      if (i == 8'hC1) begin
         if (prot) m1 = d & 8'h06;
      end else if (i == 8'hC2) begin
         m2 = (d & 8'h9C) | 8'h40;
      end else if (i == 8'hC3) begin
         n = d & 8'hFB;
         if (!prot) n[1] = m3[1];
         if (!smi_mode) n[0] = m3[0] | d[0];
         m3 = n;
      end else if (i == 8'hE8 && m3[4]) begin
         m8 = d;
      end
   endtask

   task automatic sweep();
      for (int i = 0; i < 256; i++) begin
         set_idx(8'(i));
         check(tag(8'(i)), dat_rdata, model_rd(8'(i)));
      end
   endtask

   task automatic chk_out();
      // R9 port mapping
      check("R9", {6'd0, smm_insn_en, smi_pin_en}, {6'd0, m1[2:1]});
      check("R9", {4'd0, susp_pins_en, wt_region1, susp_on_halt, nw_lock},
            {4'd0, m2[7], m2[4], m2[3], m2[2]});
      check("R9", {ser_range, map_en, susp_in_smm, nmi_in_smm, smi_lock, 1'b0},
            {m3[7:3], m3[1:0], 1'b0});
      check("R9", ext_cfg, m8);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
      logic [7:0] regs [5] = '{8'hC1, 8'hC2, 8'hE8, 8'h37, 8'hFE};
      m1 = 8'h00; m2 = 8'h40; m3 = 8'h00; m8 = 8'h85;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 index", dat_rdata, 8'hFF);   // index 00h
      sweep();                                // R1 reset values, R5 hidden
      chk_out();

      // R2: read in same cycle as index held, write visible after edge
      set_idx(8'hC2);
      check("R2 read", dat_rdata, 8'h40);
      dat_we = 1; dat_wdata = 8'h08;
      @(posedge clk); #1;
      dat_we = 0; m2 = 8'h48;
      check("R2 write", dat_rdata, 8'h48);

      // R5: map enable on, E8h visible with reset value (R1)
      wr(8'hC3, 8'h10);
      check("R1 ext reset", ext_cfg, 8'h85);
      sweep();

      // pattern sweep over lock/smi combos
      for (int s = 0; s < 4; s++) begin
         smi_mode = s[0];
         wr(8'hC3, s[1] ? 8'h11 : 8'h10);     // maybe lock
         for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 5; r++) wr(regs[r], pats[p]);
            wr(8'hC3, (pats[p] & 8'hEF) | 8'h10);
            sweep();
            chk_out();
         end
         smi_mode = 1;
         wr(8'hC3, 8'h10);
         smi_mode = 0;
      end

      // R6: locked, no SMI: protected bits dropped, others update
      smi_mode = 1; wr(8'hC1, 8'h06); wr(8'hC3, 8'h12); smi_mode = 0;
      wr(8'hC3, 8'h13);
      wr(8'hC1, 8'h00);
      set_idx(8'hC1); check("R6 c1", dat_rdata, 8'h06);
      wr(8'hC3, 8'hF9);                 // bit1 dropped, upper bits take
      set_idx(8'hC3); check("R6 c3", dat_rdata, 8'hFB);
      // R8: clear without SMI refused
      wr(8'hC3, 8'h10);
      check("R8 sticky", {7'd0, smi_lock}, 8'h01);
      // R7: with SMI, protected bit writable while locked
      smi_mode = 1;
      wr(8'hC1, 8'h02);
      set_idx(8'hC1); check("R7 c1", dat_rdata, 8'h02);
      // R8: clear with SMI allowed
      wr(8'hC3, 8'h10);
      check("R8 clear", {7'd0, smi_lock}, 8'h00);
      smi_mode = 0;
      // R5: map off hides and protects E8h
      wr(8'hE8, 8'h3C);
      wr(8'hC3, 8'h00);
      wr(8'hE8, 8'hC3);
      check("R5 hidden write", ext_cfg, 8'h3C);
      sweep();
      chk_out();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule